// File: doc/BRIEF.md
# Serial Transmitter with Register Interface

This block is an asynchronous serial transmitter attached to a small byte-wide register bus. Software programs a 12-bit baud divisor, a speed mode, a character format and two interrupt enables, then writes characters into a one-deep holding register. The holding register feeds a shift register that drives the serial line. The line rests high. Each frame is a low start bit, the data bits with the least significant bit first, an optional parity bit, and one or two high stop bits.

Two status flags report progress. The holding-empty flag shows that another character may be written. The frame-complete flag shows that the line has gone quiet. Each flag has its own enable, and the pair drives a level interrupt request output. A pulse on the acknowledge input retires a pending frame-complete request.

Register map on `bus_addr`: 0 status, 1 control, 2 format, 3 divisor low byte, 4 divisor high byte, 5 data (write only, reads 0). Every bit that is not listed below reads 0.

Top module: `ser_tx_unit`

## Requirements
- R1: Each transmitted bit lasts exactly 16*(DIV+1) clock cycles when status bit 1 (fast mode) is 0, and 8*(DIV+1) cycles when it is 1.
- R2: DIV is {divisor-high[3:0], divisor-low[7:0]}. The upper four bits written to the divisor-high register are dropped and read back as 0.
- R3: The size code is {control[2], format[2:1]}. Codes 0 to 3 send 5 to 8 data bits. Codes 4 to 7 all send 9 data bits, and the ninth bit is control[0].
- R4: A frame is a 0 start bit, then the data bits LSB first, then a parity bit if format[5:4] is 10 (even) or 11 (odd), then one stop bit (format[3]=0) or two (format[3]=1). Codes 00 and 01 send no parity. The line is 1 when idle.
- R5: Status bit 5 (holding empty) is 0 after reset. A write of 1 to control bit 3 (transmitter enable) when that bit was 0 sets it. A write to the data register clears it. It sets again on the clock edge where the character moves into the shift register. That edge is the one right after the write when the transmitter is enabled and idle, and the line shows the start bit from that edge on.
- R6: Status bit 6 (frame complete) sets on the edge that ends the last stop bit, unless another character is waiting. A one-cycle pulse on `irq_done_ack`, or a write of 1 to status bit 6, clears it. A write of 0 to status bit 6 leaves it unchanged.
- R7: `irq_empty` equals status bit 5 AND control bit 5, and `irq_done` equals status bit 6 AND control bit 6. Each output follows its flag one clock later.
- R8: A character written while a frame is being sent has its start bit begin in the cycle right after the previous last stop bit. There is no idle gap, and status bit 6 does not set between the two frames.
- R9: While control bit 3 is 0, a written character stays in the holding register and the line stays high. The character goes out once the transmitter is enabled.
- R10: After reset the line is 1, both interrupt outputs are 0, and every register reads 0. A read returns the addressed register in the cycle after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data for the address of the previous cycle |
| txd | output | 1 | Serial line, idle high |
| irq_empty | output | 1 | Holding-empty interrupt request (level) |
| irq_done | output | 1 | Frame-complete interrupt request (level) |
| irq_done_ack | input | 1 | Acknowledge that clears the frame-complete flag |

## Verification
A data write is captured on one edge. An idle, enabled transmitter loads the character on the next edge, so the start bit is expected at exactly the second falling edge after the write strobe is raised. The bench checks that latency and then compares the line against the expected frame on every cycle of the frame, which pins each bit boundary to M*(DIV+1) cycles. The frame-complete flag is due on the edge that closes the last stop bit, and the interrupt outputs are due one edge after their flag. The bench therefore checks the holding-empty interrupt on three consecutive cycles around a load, and the frame-complete interrupt two cycles after an acknowledge. Register reads are sampled one full cycle after the address is driven.

// File: rtl/ser_tx_pkg.sv
package ser_tx_pkg;

  localparam logic [2:0] RA_STAT  = 3'd0;
  localparam logic [2:0] RA_CTL   = 3'd1;
  localparam logic [2:0] RA_FMT   = 3'd2;
  localparam logic [2:0] RA_DIVLO = 3'd3;
  localparam logic [2:0] RA_DIVHI = 3'd4;
  localparam logic [2:0] RA_DATA  = 3'd5;

  localparam int FRAME_MAX = 13;
  localparam int LEN_W     = 4;

  typedef struct packed {
    logic [8:0]       data;
    logic [LEN_W-1:0] nbits;
    logic             par_en;
    logic             par_odd;
    logic             stop2;
  } frame_cfg_t;

  function automatic logic [LEN_W-1:0] size_bits(input logic [2:0] code);
    return code[2] ? LEN_W'(9) : LEN_W'(5) + LEN_W'(code[1:0]);
  endfunction

  function automatic logic [FRAME_MAX-1:0] build_frame(input frame_cfg_t c);
    logic [FRAME_MAX-1:0] f;
    logic                 p;
    f    = '1;
    f[0] = 1'b0;
    p    = c.par_odd;
    for (int i = 0; i < 9; i++) begin
      if (i < int'(c.nbits)) begin
        f[1+i] = c.data[i];
        p      = p ^ c.data[i];
      end
    end
    if (c.par_en) f[int'(c.nbits)+1] = p;
    return f;
  endfunction

  function automatic logic [LEN_W-1:0] frame_len(input frame_cfg_t c);
    return LEN_W'(2) + c.nbits + LEN_W'(c.par_en) + LEN_W'(c.stop2);
  endfunction

endpackage

// File: rtl/ser_tx_baud.sv
module ser_tx_baud #(
  parameter int DIV_W    = 12,
  parameter int OVS_NORM = 16,
  parameter int OVS_FAST = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  input  logic             fast,
  output logic             bit_end
);
  localparam int SUB_W = $clog2(OVS_NORM);

  logic [DIV_W-1:0] pre;
  logic [SUB_W-1:0] sub;
  logic             tick;
  logic             sub_last;

  assign tick     = run && (pre >= div);
  assign sub_last = (sub == (fast ? SUB_W'(OVS_FAST-1) : SUB_W'(OVS_NORM-1)));
  assign bit_end  = tick && sub_last;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      pre <= '0;
      sub <= '0;
    end else if (tick) begin
      pre <= '0;
      sub <= sub_last ? '0 : sub + 1'b1;
    end else begin
      pre <= pre + 1'b1;
    end
  end

  // R1
  tick_spacing_chk: assert property (@(posedge clk) disable iff (rst)
    tick |=> (!tick || div == '0));

endmodule

// File: rtl/ser_tx_shift.sv
module ser_tx_shift
  import ser_tx_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       tx_en,
  input  logic       hold_full,
  input  frame_cfg_t cfg,
  input  logic       bit_end,
  output logic       load,
  output logic       busy,
  output logic       frame_done,
  output logic       txd
);
  logic [FRAME_MAX-1:0] sh;
  logic [LEN_W-1:0]     left;
  logic                 last;

  assign last       = busy && bit_end && (left == LEN_W'(1));
  assign load       = tx_en && hold_full && (!busy || last);
  assign frame_done = last && !load;
  assign txd        = sh[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      sh   <= '1;
      left <= '0;
      busy <= 1'b0;
    end else if (load) begin
      sh   <= build_frame(cfg);
      left <= frame_len(cfg);
      busy <= 1'b1;
    end else if (busy && bit_end) begin
      sh   <= {1'b1, sh[FRAME_MAX-1:1]};
      left <= left - 1'b1;
      busy <= (left != LEN_W'(1));
    end
  end

  // R4
  idle_high_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> txd);

  // R4
  start_low_chk: assert property (@(posedge clk) disable iff (rst)
    load |=> !txd);

endmodule

// File: rtl/ser_tx_regs.sv
module ser_tx_regs
  import ser_tx_pkg::*;
#(
  parameter int DIV_W = 12,
  parameter int DW    = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bus_we,
  input  logic [2:0]       bus_addr,
  input  logic [DW-1:0]    bus_wdata,
  output logic [DW-1:0]    bus_rdata,
  input  logic             load,
  input  logic             frame_done,
  input  logic             ack,
  output logic             tx_en,
  output logic             fast,
  output logic [DIV_W-1:0] div,
  output logic             hold_full,
  output frame_cfg_t       cfg,
  output logic             irq_empty,
  output logic             irq_done
);
  localparam int HI_W = DIV_W - DW;

  logic            empty_f, done_f;
  logic            done_ie, empty_ie, sz_hi, ninth;
  logic [1:0]      par_mode, sz_lo;
  logic            stop2;
  logic [DW-1:0]   div_lo, hold;
  logic [HI_W-1:0] div_hi;
  logic            wr_stat, wr_ctl, wr_fmt, wr_data, en_rise;

  assign wr_stat = bus_we && bus_addr == RA_STAT;
  assign wr_ctl  = bus_we && bus_addr == RA_CTL;
  assign wr_fmt  = bus_we && bus_addr == RA_FMT;
  assign wr_data = bus_we && bus_addr == RA_DATA;
  assign en_rise = wr_ctl && bus_wdata[3] && !tx_en;

  assign div = {div_hi, div_lo};

  always_comb begin
    cfg.data    = {ninth, hold};
    cfg.nbits   = size_bits({sz_hi, sz_lo});
    cfg.par_en  = par_mode[1];
    cfg.par_odd = par_mode[0];
    cfg.stop2   = stop2;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fast     <= 1'b0;
      done_ie  <= 1'b0;
      empty_ie <= 1'b0;
      tx_en    <= 1'b0;
      sz_hi    <= 1'b0;
      ninth    <= 1'b0;
      par_mode <= 2'b00;
      stop2    <= 1'b0;
      sz_lo    <= 2'b00;
      div_lo   <= '0;
      div_hi   <= '0;
    end else begin
      if (wr_stat) fast <= bus_wdata[1];
      if (wr_ctl) begin
        done_ie  <= bus_wdata[6];
        empty_ie <= bus_wdata[5];
        tx_en    <= bus_wdata[3];
        sz_hi    <= bus_wdata[2];
        ninth    <= bus_wdata[0];
      end
      if (wr_fmt) begin
        par_mode <= bus_wdata[5:4];
        stop2    <= bus_wdata[3];
        sz_lo    <= bus_wdata[2:1];
      end
      if (bus_we && bus_addr == RA_DIVLO) div_lo <= bus_wdata;
      if (bus_we && bus_addr == RA_DIVHI) div_hi <= bus_wdata[HI_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hold      <= '0;
      hold_full <= 1'b0;
      empty_f   <= 1'b0;
      done_f    <= 1'b0;
    end else begin
      if (wr_data) begin
        hold      <= bus_wdata;
        hold_full <= 1'b1;
      end else if (load) begin
        hold_full <= 1'b0;
      end
      if (wr_data)                empty_f <= 1'b0;
      else if (load || en_rise)   empty_f <= 1'b1;
      if (frame_done)                                done_f <= 1'b1;
      else if (ack || (wr_stat && bus_wdata[6]))     done_f <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_empty <= 1'b0;
      irq_done  <= 1'b0;
      bus_rdata <= '0;
    end else begin
      irq_empty <= empty_f && empty_ie;
      irq_done  <= done_f && done_ie;
      case (bus_addr)
        RA_STAT:  bus_rdata <= {1'b0, done_f, empty_f, 3'b000, fast, 1'b0};
        RA_CTL:   bus_rdata <= {1'b0, done_ie, empty_ie, 1'b0, tx_en, sz_hi, 1'b0, ninth};
        RA_FMT:   bus_rdata <= {2'b00, par_mode, stop2, sz_lo, 1'b0};
        RA_DIVLO: bus_rdata <= div_lo;
        RA_DIVHI: bus_rdata <= DW'(div_hi);
        default:  bus_rdata <= '0;
      endcase
    end
  end

  // R6
  ack_clears_chk: assert property (@(posedge clk) disable iff (rst)
    (ack && !frame_done) |=> !done_f);

  // R5
  write_clears_empty_chk: assert property (@(posedge clk) disable iff (rst)
    wr_data |=> !empty_f);

endmodule

// File: rtl/ser_tx_unit.sv
module ser_tx_unit
  import ser_tx_pkg::*;
#(
  parameter int DIV_W    = 12,
  parameter int DW       = 8,
  parameter int OVS_NORM = 16,
  parameter int OVS_FAST = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_we,
  input  logic [2:0]    bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          txd,
  output logic          irq_empty,
  output logic          irq_done,
  input  logic          irq_done_ack
);
  logic             tx_en, fast, hold_full, load, busy, frame_done, bit_end;
  logic [DIV_W-1:0] div;
  frame_cfg_t       cfg;

  ser_tx_regs #(.DIV_W(DIV_W), .DW(DW)) u_regs (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .load(load),
    .frame_done(frame_done), .ack(irq_done_ack), .tx_en(tx_en),
    .fast(fast), .div(div), .hold_full(hold_full), .cfg(cfg),
    .irq_empty(irq_empty), .irq_done(irq_done)
  );

  ser_tx_baud #(.DIV_W(DIV_W), .OVS_NORM(OVS_NORM), .OVS_FAST(OVS_FAST)) u_baud (
    .clk(clk), .rst(rst), .run(busy), .div(div), .fast(fast),
    .bit_end(bit_end)
  );

  ser_tx_shift u_shift (
    .clk(clk), .rst(rst), .tx_en(tx_en), .hold_full(hold_full),
    .cfg(cfg), .bit_end(bit_end), .load(load), .busy(busy),
    .frame_done(frame_done), .txd(txd)
  );

  // R5
  load_has_data_chk: assert property (@(posedge clk) disable iff (rst)
    load |-> hold_full);

  // R8
  no_done_on_reload_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && load) |=> !$rose(irq_done));

endmodule

// File: tb/sim_ser_tx_unit.sv
module sim_ser_tx_unit;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_we = 1'b0;
  logic [2:0] bus_addr = 3'd0;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] bus_rdata;
  logic       txd, irq_empty, irq_done;
  logic       irq_done_ack = 1'b0;
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  ser_tx_unit u0 (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .txd(txd),
    .irq_empty(irq_empty), .irq_done(irq_done), .irq_done_ack(irq_done_ack)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] v);
    @(negedge clk); bus_addr = a;
    @(negedge clk); v = bus_rdata;
  endtask

  function automatic void exp_frame(input logic [8:0] d, input logic [2:0] code,
                                    input logic [1:0] par, input logic s2,
                                    output logic [12:0] f, output int len);
    int n, ones;
    n = (code < 3'd4) ? 5 + int'(code) : 9;
    f = '1; f[0] = 1'b0; ones = 0;
    for (int i = 0; i < n; i++) begin f[1+i] = d[i]; ones += int'(d[i]); end
    len = 1 + n;
    if (par[1]) begin f[len] = par[0] ? ~ones[0] : ones[0]; len++; end
    len += 1 + int'(s2);
  endfunction

  // waits for the start bit, then compares the line on every cycle
  task automatic observe(input string req, input logic [12:0] f, input int len, input int p);
    int lat, mism;
    lat = 0;
    while (txd === 1'b1 && lat < 20) begin @(negedge clk); lat++; end
    chk({req, " R5 start latency"}, lat, 1);
    mism = 0;
    for (int i = 0; i < len * p; i++) begin
      if (txd !== f[i / p]) mism++;
      @(negedge clk);
    end
    chk({req, " R1 R4 waveform mismatches"}, mism, 0);
    chk({req, " R4 idle high"}, int'(txd), 1);
  endtask

  task automatic send(input int div, input logic fast, input logic [2:0] code,
                      input logic [1:0] par, input logic s2, input logic [8:0] d,
                      input logic ie);
    logic [12:0] f; int len, p; logic [7:0] v;
    exp_frame(d, code, par, s2, f, len);
    p = (fast ? 8 : 16) * (div + 1);
    wr(3'd3, div[7:0]);
    wr(3'd4, {4'h0, div[11:8]});
    wr(3'd0, {1'b0, 1'b1, 4'b0, fast, 1'b0});
    wr(3'd2, {2'b00, par, s2, code[1:0], 1'b0});
    wr(3'd1, {1'b0, ie, 2'b00, 1'b1, code[2], 1'b0, d[8]});
    wr(3'd5, d[7:0]);
    observe("R3", f, len, p);
    rd(3'd0, v);
    chk("R6 done flag after frame", int'(v[6]), 1);
    chk("R5 empty flag after frame", int'(v[5]), 1);
    chk("R7 irq_done follows enable", int'(irq_done), int'(ie));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] v;
    logic [12:0] f1, f2;
    int l1, l2, mism, hit;
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    chk("R10 txd idle", int'(txd), 1);
    chk("R10 irq_empty", int'(irq_empty), 0);
    chk("R10 irq_done", int'(irq_done), 0);
    for (int a = 0; a < 6; a++) begin
      rd(3'(a), v);
      chk("R10 register reset", int'(v), 0);
    end
    // R5 enable edge sets empty flag
    wr(3'd1, 8'h08);
    rd(3'd0, v);
    chk("R5 empty set by enable", int'(v[5]), 1);
    // R9 disabled transmitter holds data
    wr(3'd1, 8'h00);
    wr(3'd2, 8'h06);
    wr(3'd5, 8'hA5);
    rd(3'd0, v);
    chk("R5 data write clears empty", int'(v[5]), 0);
    hit = 0;
    repeat (60) begin @(negedge clk); if (txd !== 1'b1) hit++; end
    chk("R9 line quiet while disabled", hit, 0);
    exp_frame(9'h0A5, 3'd3, 2'b00, 1'b0, f1, l1);
    wr(3'd1, 8'h08);
    observe("R9", f1, l1, 16);
    // R2 divisor high byte masking and long period
    wr(3'd4, 8'hF3);
    rd(3'd4, v);
    chk("R2 divisor high masked", int'(v), 3);
    send(258, 1'b1, 3'd0, 2'b00, 1'b0, 9'h013, 1'b0);
    // R4 parity, stop and size corners
    send(1, 1'b0, 3'd7, 2'b11, 1'b1, 9'h1FF, 1'b1);
    send(0, 1'b0, 3'd4, 2'b10, 1'b0, 9'h100, 1'b1);
    send(2, 1'b1, 3'd1, 2'b01, 1'b1, 9'h02A, 1'b0);
    // R6 acknowledge and write clearing
    chk("R7 irq_done pending", int'(irq_done), 0);
    wr(3'd1, 8'h48);
    @(negedge clk);
    chk("R7 irq_done with enable", int'(irq_done), 1);
    wr(3'd0, 8'h02);
    rd(3'd0, v);
    chk("R6 writing 0 keeps flag", int'(v[6]), 1);
    @(negedge clk); irq_done_ack = 1'b1;
    @(negedge clk); irq_done_ack = 1'b0;
    @(negedge clk);
    chk("R6 ack drops irq_done", int'(irq_done), 0);
    rd(3'd0, v);
    chk("R6 ack clears flag", int'(v[6]), 0);
    // R7 holding-empty request around a load
    wr(3'd0, 8'h00);
    wr(3'd4, 8'h00);
    wr(3'd3, 8'h00);
    wr(3'd2, 8'h06);
    wr(3'd1, 8'h28);
    @(negedge clk);
    chk("R7 irq_empty idle", int'(irq_empty), 1);
    wr(3'd5, 8'h3C);
    chk("R7 irq_empty at write", int'(irq_empty), 1);
    @(negedge clk);
    chk("R7 irq_empty low after write", int'(irq_empty), 0);
    @(negedge clk);
    chk("R7 irq_empty after load", int'(irq_empty), 1);
    repeat (200) @(negedge clk);
    // R8 back-to-back frames
    wr(3'd0, 8'h40);
    wr(3'd1, 8'h48);
    exp_frame(9'h0C3, 3'd3, 2'b10, 1'b0, f1, l1);
    exp_frame(9'h05E, 3'd3, 2'b10, 1'b0, f2, l2);
    wr(3'd2, 8'h26);
    wr(3'd5, 8'hC3);
    @(negedge clk);
    mism = 0; hit = 0;
    fork
      begin
        for (int i = 0; i < (l1 + l2) * 16; i++) begin
          if (i < l1 * 16) begin if (txd !== f1[i / 16]) mism++; end
          else if (txd !== f2[(i - l1 * 16) / 16]) mism++;
          if (irq_done !== 1'b0) hit++;
          @(negedge clk);
        end
      end
      begin
        repeat (5) @(negedge clk);
        bus_we = 1'b1; bus_addr = 3'd5; bus_wdata = 8'h5E;
        @(negedge clk); bus_we = 1'b0;
      end
    join
    chk("R8 gapless two frames", mism, 0);
    chk("R8 no done between frames", hit, 0);
    @(negedge clk);
    chk("R7 R8 irq_done after last frame", int'(irq_done), 1);
    // constrained random frames
    for (int k = 0; k < 12; k++) begin
      logic [2:0] code; logic [1:0] par; logic [8:0] d;
      code = 3'($urandom_range(0, 7));
      par  = 2'($urandom_range(0, 3));
      d    = 9'($urandom);
      send(int'($urandom_range(0, 5)), 1'($urandom), code, par, 1'($urandom), d, 1'($urandom));
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule